// File: doc/BRIEF.md
# NaN Result Selector for Two-Operand Single-Precision Operations

This block sits beside the datapath of a two-input single-precision floating-point unit. It handles the case where at least one operand is a NaN. It classifies both 32-bit operands internally, decides which NaN becomes the result under a run-time policy, and quiets that NaN if it is signaling. It also raises an invalid-operation flag whenever a signaling NaN is present. A separate control forces the canonical default NaN as the result. Arithmetic on ordinary numbers is handled elsewhere.

The selection logic is purely combinational and feeds a single output register stage. The surrounding pipeline therefore sees all three results one clock after it presents the operands. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `nan_select_unit`

## Requirements
- R1: All outputs are registered. They appear on the first rising edge after the inputs are applied, and read zero while reset is active.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. Bit 22 set means quiet, and bit 22 clear means signaling. `nan_valid` is high exactly when at least one operand is a NaN.
- R3: `invalid_flg` is high exactly when at least one operand is a signaling NaN, in every policy and also when `dflt_mode` is set.
- R4: When `dflt_mode` is 1, `nan_res` is 0x7FC00000 whatever the operands and policy are.
- R5: Policy 0 (`mode`=0) chooses A if A is signaling, else B if B is signaling, else A if A is quiet, else B.
- R6: Policy 1 chooses A whenever A is any NaN, and B otherwise.
- R7: Policy 2 chooses B whenever B is any NaN, and A otherwise.
- R8: Policy 3 prefers the quiet NaN when one operand is signaling and the other is quiet. When only one operand is a NaN, it chooses that one.
- R9: In policy 3, when both operands are NaNs of the same kind, it chooses the larger magnitude (bits 30:0). On equal magnitudes it chooses A only if A is positive and B is negative, and B otherwise.
- R10: The result is the chosen operand with bit 22 forced to 1 and every other bit unchanged, so a selected signaling NaN leaves quieted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| mode | input | 2 | Propagation policy: 0 signaling-first, 1 first-NaN, 2 second-NaN, 3 larger-magnitude |
| dflt_mode | input | 1 | Force the default NaN as the result |
| nan_res | output | 32 | Selected, quieted NaN (or default NaN) |
| nan_valid | output | 1 | At least one operand was a NaN |
| invalid_flg | output | 1 | At least one operand was a signaling NaN |

## Verification
Each of `nan_res`, `nan_valid` and `invalid_flg` is due exactly one rising edge after its operands, policy and default control are applied, and none has a longer path. The bench changes inputs on a falling edge and reads all three outputs on the next falling edge. That edge comes after the single capturing rising edge and before the next inputs are applied. The sweep covers every pairing of a small operand set, which includes ties and opposite signs, under all four policies with the default control both off and on. The result is compared only when `nan_valid` is expected high or `dflt_mode` is set.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;

  typedef enum logic [1:0] {
    PICK_SIG_FIRST  = 2'd0,
    PICK_FIRST_NAN  = 2'd1,
    PICK_SECOND_NAN = 2'd2,
    PICK_BIG_MAG    = 2'd3
  } pick_mode_e;

  typedef struct packed {
    logic any;
    logic sig;
    logic qui;
  } nan_cls_t;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = nanprop_pkg::EXP_W,
  parameter int FRAC_W = nanprop_pkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output nan_cls_t          cls,
  output logic [WORD_W-2:0] mag,
  output logic              sign
);
  logic exp_ones;
  logic frac_nz;
  logic qbit;

  always_comb begin
    exp_ones = &word[WORD_W-2 -: EXP_W];
    frac_nz  = |word[FRAC_W-1:0];
    qbit     = word[FRAC_W-1];
    cls.any  = exp_ones && frac_nz;
    cls.qui  = exp_ones && qbit;
    cls.sig  = exp_ones && frac_nz && !qbit;
    mag      = word[WORD_W-2:0];
    sign     = word[WORD_W-1];
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nanprop_pkg::*;
#(
  parameter int MAG_W = nanprop_pkg::EXP_W + nanprop_pkg::FRAC_W
) (
  input  pick_mode_e       mode,
  input  nan_cls_t         cls_a,
  input  nan_cls_t         cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             sign_a,
  input  logic             sign_b,
  output logic             take_b
);
  logic a_wins_mag;

  always_comb begin
    if (mag_a != mag_b) a_wins_mag = (mag_a > mag_b);
    else                a_wins_mag = !sign_a && sign_b;
  end

  always_comb begin
    take_b = 1'b0;
    unique case (mode)
      PICK_SIG_FIRST: begin
        if (cls_a.sig)      take_b = 1'b0;
        else if (cls_b.sig) take_b = 1'b1;
        else if (cls_a.qui) take_b = 1'b0;
        else                take_b = 1'b1;
      end
      PICK_FIRST_NAN:  take_b = !cls_a.any;
      PICK_SECOND_NAN: take_b = cls_b.any;
      PICK_BIG_MAG: begin
        if (!cls_a.any)                  take_b = 1'b1;
        else if (!cls_b.any)             take_b = 1'b0;
        else if (cls_a.sig && cls_b.qui) take_b = 1'b1;
        else if (cls_a.qui && cls_b.sig) take_b = 1'b0;
        else                             take_b = !a_wins_mag;
      end
      default: take_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/nan_select_unit.sv
module nan_select_unit
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = nanprop_pkg::EXP_W,
  parameter int FRAC_W = nanprop_pkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [1:0]        mode,
  input  logic              dflt_mode,
  output logic [WORD_W-1:0] nan_res,
  output logic              nan_valid,
  output logic              invalid_flg
);
  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
  localparam logic [WORD_W-1:0] DFLT_NAN  =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // operand classification, one per input
  logic [WORD_W-1:0] opnd [2];
  nan_cls_t          cls  [2];
  logic [MAG_W-1:0]  mag  [2];
  logic              sgn  [2];
  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (opnd[gi]),
      .cls  (cls[gi]),
      .mag  (mag[gi]),
      .sign (sgn[gi])
    );
  end

  logic take_b;
  nan_pick #(.MAG_W(MAG_W)) u_pick (
    .mode   (pick_mode_e'(mode)),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .sign_a (sgn[0]),
    .sign_b (sgn[1]),
    .take_b (take_b)
  );

  // next-state
  logic [WORD_W-1:0] res_d;
  logic              valid_d;
  logic              inv_d;
  always_comb begin
    res_d   = dflt_mode ? DFLT_NAN : ((take_b ? op_b : op_a) | QUIET_BIT);
    valid_d = cls[0].any | cls[1].any;
    inv_d   = cls[0].sig | cls[1].sig;
  end

  // output register
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      nan_res     <= '0;
      nan_valid   <= 1'b0;
      invalid_flg <= 1'b0;
    end else begin
      nan_res     <= res_d;
      nan_valid   <= valid_d;
      invalid_flg <= inv_d;
    end
  end

  // checks
  assert_valid_tracks_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !(cls[0].any || cls[1].any) |=> !nan_valid);

  assert_invalid_raise_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (cls[0].sig || cls[1].sig) |=> invalid_flg);

  assert_default_nan_R4: assert property (@(posedge clk) disable iff (!rst_q)
    dflt_mode |=> nan_res == DFLT_NAN);

  assert_sig_first_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd0 && !dflt_mode && cls[0].sig) |=> nan_res == ($past(op_a) | QUIET_BIT));

  assert_first_nan_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd1 && !dflt_mode && cls[0].any) |=> nan_res == ($past(op_a) | QUIET_BIT));

  assert_second_nan_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (mode == 2'd2 && !dflt_mode && cls[1].any) |=> nan_res == ($past(op_b) | QUIET_BIT));

  assert_out_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q)
    nan_valid |-> (nan_res[FRAC_W-1] && (&nan_res[WORD_W-2 -: EXP_W])));
endmodule

// File: tb/nan_select_unit_tb.sv
module nan_select_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] DFLT = 32'h7FC0_0000;
  localparam int NVALS = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] op_a, op_b;
  logic [1:0]  mode;
  logic        dflt_mode;
  logic [31:0] nan_res;
  logic        nan_valid, invalid_flg;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nan_select_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .mode(mode),
    .dflt_mode(dflt_mode), .nan_res(nan_res), .nan_valid(nan_valid),
    .invalid_flg(invalid_flg)
  );

  function automatic logic [31:0] val(int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h3F80_0000;
      2:  return 32'h7F80_0000;
      3:  return 32'h7FC0_0000;
      4:  return 32'h7FC0_0001;
      5:  return 32'hFFC0_0001;
      6:  return 32'h7F80_0001;
      7:  return 32'h7FA0_0000;
      8:  return 32'hFFA0_0000;
      9:  return 32'h7FFF_FFFF;
      10: return 32'hFF80_0001;
      default: return 32'h7FA0_0010;
    endcase
  endfunction

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit is_sn(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_qn(logic [31:0] x);
    return is_nan(x) && x[22];
  endfunction

  // returns 1 when B is the expected choice
  function automatic bit want_b(logic [31:0] a, logic [31:0] b, int m);
    case (m)
      0: begin
        if (is_sn(a)) return 0;
        if (is_sn(b)) return 1;
        if (is_qn(a)) return 0;
        return 1;
      end
      1: return !is_nan(a);
      2: return is_nan(b);
      default: begin
        if (is_nan(a) && !is_nan(b)) return 0;
        if (!is_nan(a)) return 1;
        if (is_sn(a) != is_sn(b)) return is_sn(a);
        if (a[30:0] > b[30:0]) return 0;
        if (a[30:0] < b[30:0]) return 1;
        return !(a[31] == 1'b0 && b[31] == 1'b1);
      end
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h mode=%0d dflt=%0b)",
               tag, got, exp, op_a, op_b, mode, dflt_mode);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; mode = '0; dflt_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    check("R1 reset res", nan_res, 32'h0);
    check("R1 reset valid", {31'b0, nan_valid}, 32'h0);
    check("R1 reset invalid", {31'b0, invalid_flg}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 4; m++) begin
        for (int i = 0; i < NVALS; i++) begin
          for (int j = 0; j < NVALS; j++) begin
            logic [31:0] a, b, exp_res;
            bit ev, ei, same_kind;
            string tag;
            a = val(i); b = val(j);
            op_a = a; op_b = b; mode = 2'(m); dflt_mode = d[0];
            ev = is_nan(a) || is_nan(b);
            ei = is_sn(a) || is_sn(b);
            exp_res = (want_b(a, b, m) ? b : a) | 32'h0040_0000;
            same_kind = is_nan(a) && is_nan(b) && (is_sn(a) == is_sn(b));
            @(negedge clk);  // one rising edge has captured the inputs (R1)
            check("R2 nan_valid", {31'b0, nan_valid}, {31'b0, ev});
            check("R3 invalid_flg", {31'b0, invalid_flg}, {31'b0, ei});
            if (d == 1) begin
              check("R4 default nan", nan_res, DFLT);
            end else if (ev) begin
              case (m)
                0: tag = "R5 signaling-first";
                1: tag = "R6 first-nan";
                2: tag = "R7 second-nan";
                default: tag = same_kind ? "R9 magnitude/sign" : "R8 class preference";
              endcase
              if (is_sn(want_b(a, b, m) ? b : a))
                tag = {tag, " R10 quieted"};
              check(tag, nan_res, exp_res);
            end
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule